// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control sequencer of a small 8-bit processor core. It owns the global interrupt enable flag. It decides in which cycle a pending request is accepted, and it then steps through the entry sequence. That sequence saves the 16-bit program counter as two bytes on a downward-growing, byte-wide stack and then hands the core a vector address. On a return-from-interrupt decode strobe it runs the reverse sequence. It pops both bytes, hands the restored program counter to the core and sets the global enable again.

Requests are accepted only at an instruction boundary, so a multi-cycle instruction always finishes first. An instruction that sets the global enable is always followed by one more instruction before any request is taken. When the core is asleep, no boundary strobe is needed to accept a request, but the entry sequence is preceded by four extra wait cycles. While a sequence runs, the block raises a busy flag and the core stalls. The stack memory is outside the block: writes are combinational strobes, and read data is expected one cycle after the read strobe.

Top module: `irq_seq`

## Requirements
- R1: After reset the stack pointer equals SP_INIT, the global enable flag, busy, stack write, stack read and program-counter load are all low.
- R2: A request is accepted at a clock edge only when the global enable is high, at least one bit of irqPend is set, the block is idle, and instrDone is high (or sleeping is high). With the enable low, or with instrDone low during a multi-cycle instruction, nothing is accepted. Acceptance clears the global enable, and it stays low for the whole entry sequence.
- R3: The entry sequence first writes the low program-counter byte at the current stack pointer S. It then writes the high byte at S-1. Each write decrements the stack pointer, which ends at S-2.
- R4: After acceptance from the awake state, busy is high for exactly four cycles. The first two cycles are the pushes, and pcLoad is high only in the fourth.
- R5: After acceptance while sleeping, busy is high for exactly eight cycles. The pushes fall in cycles five and six, and pcLoad is high only in cycle eight.
- R6: A seiStrobe while idle sets the global enable in the next cycle. The next instrDone does not accept a pending request; the instrDone after it does.
- R7: A retiStrobe while idle starts a four-cycle return. Cycle one reads the stack at S+1, and cycle two reads at S+2. The stack pointer ends at S+2. In cycle four pcLoad is high with pcLoadVal equal to {byte read first, byte read second}. The global enable is high from the next cycle on.
- R8: While busy, instrDone, seiStrobe and retiStrobe have no effect: the global enable stays low after an entry, and the sequence is not changed.
- R9: With several requests pending, the lowest-numbered index i is taken, and pcLoadVal at the end of entry is VEC_BASE + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPend | input | NUM_IRQ | Pending request lines, bit i is request i |
| instrDone | input | 1 | High in the last cycle of an instruction |
| sleeping | input | 1 | Core is in sleep |
| seiStrobe | input | 1 | Decode of the instruction that sets the global enable |
| retiStrobe | input | 1 | Decode of return-from-interrupt |
| pcIn | input | 16 | Program counter to save on entry |
| stkRdata | input | 8 | Stack read data, valid the cycle after stkRe |
| stkWe | output | 1 | Stack write strobe |
| stkRe | output | 1 | Stack read strobe |
| stkAddr | output | SP_W | Stack access address |
| stkWdata | output | 8 | Stack write data |
| sp | output | SP_W | Stack pointer |
| pcLoad | output | 1 | Load pcLoadVal into the program counter |
| pcLoadVal | output | 16 | Vector address or restored program counter |
| gieFlag | output | 1 | Global interrupt enable |
| busy | output | 1 | Entry or return sequence running |

## Verification
All timing is counted from the clock edge that samples the accepting strobe. Busy and the first push appear in the cycle just after that edge. The vector load comes three cycles later, or seven when waking. The return strobe is handled the same way, and its restored value arrives four cycles after its edge. The bench drives inputs one time unit after each rising edge and compares every output in every cycle of a sequence against a per-cycle expectation built from these offsets. It never waits for an event, so a result one cycle early or late is reported.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_ENTRY,
    ST_RET
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch pc and winning index
    logic push;     // write stack, decrement sp
    logic pushHi;   // select high pc byte for the write
    logic pop;      // read stack at sp+1, increment sp
    logic capHi;    // latch first popped byte
    logic capLo;    // latch second popped byte
    logic loadVec;  // present vector address
    logic loadRet;  // present restored pc
  } seq_ctl_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyPend,
  input  logic     instrDone,
  input  logic     sleeping,
  input  logic     seiStrobe,
  input  logic     retiStrobe,
  output seq_ctl_t ctl,
  output logic     gieFlag,
  output logic     busy
);
  seq_state_e state;
  logic [1:0] cnt;
  logic       skipOne;
  logic       accept;
  logic       startRet;

  assign startRet = (state == ST_IDLE) && retiStrobe;
  assign accept   = (state == ST_IDLE) && !retiStrobe && gieFlag && anyPend &&
                    (sleeping || (instrDone && !skipOne));
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      gieFlag <= 1'b0;
      skipOne <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= sleeping ? ST_WAKE : ST_ENTRY;
            cnt     <= '0;
            gieFlag <= 1'b0;
            skipOne <= 1'b0;
          end else if (startRet) begin
            state <= ST_RET;
            cnt   <= '0;
          end else if (seiStrobe) begin
            gieFlag <= 1'b1;
            skipOne <= 1'b1;
          end else if (instrDone) begin
            skipOne <= 1'b0;
          end
        end
        ST_WAKE: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_ENTRY;
        end
        ST_ENTRY: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_IDLE;
        end
        default: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            state   <= ST_IDLE;
            gieFlag <= 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.capture = accept;
    ctl.push    = (state == ST_ENTRY) && (cnt < 2'd2);
    ctl.pushHi  = (state == ST_ENTRY) && (cnt == 2'd1);
    ctl.loadVec = (state == ST_ENTRY) && (cnt == 2'd3);
    ctl.pop     = (state == ST_RET) && (cnt < 2'd2);
    ctl.capHi   = (state == ST_RET) && (cnt == 2'd1);
    ctl.capLo   = (state == ST_RET) && (cnt == 2'd2);
    ctl.loadRet = (state == ST_RET) && (cnt == 2'd3);
  end

  // R2
  entry_gie_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_WAKE, ST_ENTRY}) |-> !gieFlag);

  // R4
  load_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadVec || ctl.loadRet) |=> !busy);

  // R7
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRet |=> gieFlag);

  // R8
  busy_seq_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && cnt != 2'd3) |=> (state == ST_ENTRY));
endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int               NUM_IRQ  = 8,
  parameter int               SP_W     = 8,
  parameter logic [SP_W-1:0]  SP_INIT  = '1,
  parameter logic [PC_W-1:0]  VEC_BASE = 16'h0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_ctl_t            ctl,
  input  logic [NUM_IRQ-1:0]  irqPend,
  input  logic [PC_W-1:0]     pcIn,
  input  logic [BYTE_W-1:0]   stkRdata,
  output logic                anyPend,
  output logic                stkWe,
  output logic                stkRe,
  output logic [SP_W-1:0]     stkAddr,
  output logic [BYTE_W-1:0]   stkWdata,
  output logic [SP_W-1:0]     sp,
  output logic                pcLoad,
  output logic [PC_W-1:0]     pcLoadVal
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [IDX_W-1:0]  pendIdx;
  logic [IDX_W-1:0]  vecIdx;
  logic [PC_W-1:0]   pcSave;
  logic [BYTE_W-1:0] popHi;
  logic [BYTE_W-1:0] popLo;
  logic [SP_W-1:0]   spUp;

  // lowest index wins
  always_comb begin
    pendIdx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqPend[i]) pendIdx = IDX_W'(i);
    end
  end

  assign anyPend   = |irqPend;
  assign spUp      = sp + SP_W'(1);
  assign stkWe     = ctl.push;
  assign stkRe     = ctl.pop;
  assign stkAddr   = ctl.pop ? spUp : sp;
  assign stkWdata  = ctl.pushHi ? pcSave[PC_W-1:BYTE_W] : pcSave[BYTE_W-1:0];
  assign pcLoad    = ctl.loadVec || ctl.loadRet;
  assign pcLoadVal = ctl.loadRet ? {popHi, popLo}
                                 : VEC_BASE + {{(PC_W-IDX_W){1'b0}}, vecIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp     <= SP_INIT;
      pcSave <= '0;
      vecIdx <= '0;
      popHi  <= '0;
      popLo  <= '0;
    end else begin
      if (ctl.capture) begin
        pcSave <= pcIn;
        vecIdx <= pendIdx;
      end
      if (ctl.push)       sp <= sp - SP_W'(1);
      else if (ctl.pop)   sp <= spUp;
      if (ctl.capHi) popHi <= stkRdata;
      if (ctl.capLo) popLo <= stkRdata;
    end
  end

  // R3
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkWe |=> (sp == $past(sp) - SP_W'(1)));

  // R7
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkRe |=> (sp == $past(sp) + SP_W'(1)));

  // R3
  no_push_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stkWe && stkRe));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int               NUM_IRQ  = 8,
  parameter int               SP_W     = 8,
  parameter logic [SP_W-1:0]  SP_INIT  = '1,
  parameter logic [15:0]      VEC_BASE = 16'h0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic               instrDone,
  input  logic               sleeping,
  input  logic               seiStrobe,
  input  logic               retiStrobe,
  input  logic [15:0]        pcIn,
  input  logic [7:0]         stkRdata,
  output logic               stkWe,
  output logic               stkRe,
  output logic [SP_W-1:0]    stkAddr,
  output logic [7:0]         stkWdata,
  output logic [SP_W-1:0]    sp,
  output logic               pcLoad,
  output logic [15:0]        pcLoadVal,
  output logic               gieFlag,
  output logic               busy
);
  seq_ctl_t ctl;
  logic     anyPend;

  irq_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyPend    (anyPend),
    .instrDone  (instrDone),
    .sleeping   (sleeping),
    .seiStrobe  (seiStrobe),
    .retiStrobe (retiStrobe),
    .ctl        (ctl),
    .gieFlag    (gieFlag),
    .busy       (busy)
  );

  irq_seq_dp #(
    .NUM_IRQ  (NUM_IRQ),
    .SP_W     (SP_W),
    .SP_INIT  (SP_INIT),
    .VEC_BASE (VEC_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .irqPend   (irqPend),
    .pcIn      (pcIn),
    .stkRdata  (stkRdata),
    .anyPend   (anyPend),
    .stkWe     (stkWe),
    .stkRe     (stkRe),
    .stkAddr   (stkAddr),
    .stkWdata  (stkWdata),
    .sp        (sp),
    .pcLoad    (pcLoad),
    .pcLoadVal (pcLoadVal)
  );
endmodule

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int          NIRQ = 8;
  localparam int          SPW  = 8;
  localparam logic [7:0]  SPI  = 8'hFF;
  localparam logic [15:0] VB   = 16'h0001;

  logic clk, rstN;
  logic [NIRQ-1:0] irqPend;
  logic instrDone, sleeping, seiStrobe, retiStrobe;
  logic [15:0] pcIn;
  logic [7:0] stkRdata;
  logic stkWe, stkRe;
  logic [SPW-1:0] stkAddr;
  logic [7:0] stkWdata;
  logic [SPW-1:0] sp;
  logic pcLoad;
  logic [15:0] pcLoadVal;
  logic gieFlag, busy;

  irq_seq #(.NUM_IRQ(NIRQ), .SP_W(SPW), .SP_INIT(SPI), .VEC_BASE(VB)) i_irq_seq (
    .clk(clk), .rstN(rstN), .irqPend(irqPend), .instrDone(instrDone),
    .sleeping(sleeping), .seiStrobe(seiStrobe), .retiStrobe(retiStrobe),
    .pcIn(pcIn), .stkRdata(stkRdata), .stkWe(stkWe), .stkRe(stkRe),
    .stkAddr(stkAddr), .stkWdata(stkWdata), .sp(sp), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .gieFlag(gieFlag), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] stackMem [256];
  always_ff @(posedge clk) begin
    if (stkWe) stackMem[stkAddr] <= stkWdata;
    if (stkRe) stkRdata <= stackMem[stkAddr];
  end

  int checks = 0;
  int fails  = 0;
  logic [7:0] spExp;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clearIn();
    instrDone = 0; sleeping = 0; seiStrobe = 0; retiStrobe = 0;
  endtask

  // gie must be high and no skip pending
  task automatic doEntry(input logic [15:0] pc, input logic [7:0] pend, input bit slp);
    int off, last;
    off  = slp ? 4 : 0;
    last = off + 3;
    pcIn = pc; irqPend = pend;
    if (slp) sleeping = 1; else instrDone = 1;
    cyc();
    clearIn();
    for (int i = 0; i <= last; i++) begin
      chk(slp ? "R5 busy" : "R4 busy", busy, 1);
      chk("R2 gie low in entry", gieFlag, 0);
      if (i == off) begin
        chk("R3 push lo we", stkWe, 1);
        chk("R3 push lo addr", stkAddr, spExp);
        chk("R3 push lo data", stkWdata, pc[7:0]);
      end else if (i == off + 1) begin
        chk("R3 push hi we", stkWe, 1);
        chk("R3 push hi addr", stkAddr, spExp - 8'd1);
        chk("R3 push hi data", stkWdata, pc[15:8]);
      end else begin
        chk(slp ? "R5 no write" : "R4 no write", stkWe, 0);
      end
      chk(slp ? "R5 pcLoad" : "R4 pcLoad", pcLoad, (i == last));
      if (i == last) chk("R9 vector", pcLoadVal, VB + 16'(lowIdx(pend)));
      // R8: stray strobes while busy
      if (i < last) begin
        seiStrobe  = $urandom % 2;
        retiStrobe = $urandom % 2;
        instrDone  = $urandom % 2;
      end else begin
        clearIn();
      end
      cyc();
    end
    clearIn();
    irqPend = '0;
    spExp = spExp - 8'd2;
    chk(slp ? "R5 idle after" : "R4 idle after", busy, 0);
    chk("R8 gie stays low", gieFlag, 0);
    chk("R3 sp after entry", sp, spExp);
  endtask

  task automatic doReturn(input logic [15:0] pc);
    retiStrobe = 1;
    cyc();
    clearIn();
    for (int i = 0; i < 4; i++) begin
      chk("R7 busy", busy, 1);
      chk("R7 read strobe", stkRe, (i < 2));
      if (i < 2) chk("R7 read addr", stkAddr, spExp + 8'(i + 1));
      chk("R7 pcLoad", pcLoad, (i == 3));
      if (i == 3) chk("R7 restored pc", pcLoadVal, pc);
      cyc();
    end
    spExp = spExp + 8'd2;
    chk("R7 idle", busy, 0);
    chk("R7 gie set", gieFlag, 1);
    chk("R7 sp", sp, spExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; irqPend = '0; pcIn = '0; clearIn();
    repeat (3) cyc();
    chk("R1 sp", sp, SPI);
    chk("R1 busy", busy, 0);
    chk("R1 gie", gieFlag, 0);
    chk("R1 we", stkWe, 0);
    chk("R1 re", stkRe, 0);
    chk("R1 pcLoad", pcLoad, 0);
    rstN = 1;
    spExp = SPI;
    cyc();

    // R2: enable low, nothing taken
    irqPend = 8'h04; instrDone = 1;
    cyc();
    chk("R2 gie off no accept", busy, 0);

    // R6: enable then one more instruction
    seiStrobe = 1; instrDone = 1;
    cyc();
    seiStrobe = 0;
    chk("R6 gie set", gieFlag, 1);
    instrDone = 1;
    cyc();
    chk("R6 next instr not interrupted", busy, 0);
    // R2: multi-cycle instruction, no boundary
    instrDone = 0;
    repeat (3) begin
      cyc();
      chk("R2 mid instruction no accept", busy, 0);
    end

    doEntry(16'hA55A, 8'h0C, 0);
    doReturn(16'hA55A);
    doEntry(16'h1234, 8'h80, 1);
    doReturn(16'h1234);
    doEntry(16'hFFFF, 8'hFF, 0);
    doReturn(16'hFFFF);

    for (int n = 0; n < 24; n++) begin
      logic [15:0] pc;
      logic [7:0] pend;
      bit slp;
      pc   = 16'($urandom);
      pend = 8'($urandom);
      if (pend == 0) pend = 8'h10;
      slp  = ($urandom % 3) == 0;
      doEntry(pc, pend, slp);
      repeat ($urandom % 3) cyc();
      doReturn(pc);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule